// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block keeps a free-running count of seconds. It runs entirely on the fast system clock. A separate 1 Hz tick input is brought into that clock through a synchronizer, and each rising edge of the tick advances the count by one while counting is enabled. Software programs a start value and an alarm value through a small register port. The start value is not written into the counter directly. It is held as a pending load and takes the place of the increment on the next tick edge.

Whenever the count equals the alarm value, a raw interrupt is raised. The comparison is combinational in the system clock domain, so the raw status rises in the same system cycle as the count reaches the alarm. The raw state is sticky until software clears it. A clear issued while the count still equals the alarm has no effect. A mask bit gates the raw state onto the interrupt pin.

The register port is a plain single-cycle port. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`. The port has no back-pressure, because every access completes in one cycle. Writing 1 to bit 0 of the software-reset register returns the whole block to its reset state, exactly as `rst` does.

Top module: `sec_alarm_counter`

## Requirements
- R1: Address 0 reads back the current count. A write to address 0 is ignored and the count is unchanged.
- R2: While bit 0 of the control register (address 3) is 1, each rising edge of `tick_1hz` increments the count by one. The new count is readable 3 clock cycles after the edge at the pin. While that bit is 0, tick edges leave the count unchanged.
- R3: A write to the load register (address 1) does not change the count at once. On the next tick edge that arrives while counting is enabled, the load value replaces the increment. A load stays pending across tick edges that arrive while counting is disabled.
- R4: Bit 0 of the raw status register (address 5) is 1 in every cycle in which the count equals the match register (address 2). It rises in the same cycle as the count changes to the match value, and it stays 1 afterwards until it is cleared.
- R5: Writing a value with bit 0 set to the clear register (address 6), while the count differs from the match value, returns the raw status to 0 on the next cycle.
- R6: A clear written while the count equals the match value has no effect: the raw status stays 1.
- R7: `irq` equals the raw status ANDed with bit 0 of the mask register (address 4).
- R8: Writing a value with bit 0 set to the software-reset register (address 7) returns the count, load, match, control and mask registers and the raw status to their reset values on the next cycle.
- R9: The count wraps from all ones to zero, and a match value of zero is detected after the wrap.
- R10: After `rst`, the count, load, match, control and mask registers all read 0 and `irq` is 0. Because the count and the match value are then equal, the raw status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | Asynchronous 1 Hz tick; each rising edge advances the count |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Masked interrupt |

## Verification
A tick edge at the pin reaches the count 3 clock cycles later: two synchronizer stages and one counter register. The bench raises the tick on a falling edge, waits three rising edges and samples at the following falling edge. Register writes, clears and software reset take effect at the rising edge on which the strobe is seen, so their results are read at the next falling edge. The raw status and `irq` are combinational from the count, so the match test samples after the second rising edge to confirm that the status is still low, and after the third to confirm that it has risen in the same cycle as the count.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RAW   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLEAR = 3'd6;
  localparam logic [ADDR_W-1:0] A_SWRST = 3'd7;
endpackage

// File: rtl/sac_tick_sync.sv
module sac_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick_i,
  output logic adv_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst || clr) chain_q[g] <= 1'b0;
          else            chain_q[g] <= tick_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst || clr) chain_q[g] <= 1'b0;
          else            chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) last_q <= 1'b0;
    else            last_q <= chain_q[STAGES-1];
  end

  assign adv_o = chain_q[STAGES-1] & ~last_q;

  // R2: one advance pulse per tick edge
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (adv_o && !clr) |=> !adv_o);
endmodule

// File: rtl/sac_count_core.sv
module sac_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv_i,
  input  logic         en_i,
  input  logic         load_wr_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;
  logic         pend_q;
  logic         step;

  assign step = adv_i & en_i;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (step) begin
      if (pend_q) count_q <= load_val_i;
      else        count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   pend_q <= 1'b0;
    else if (load_wr_i) pend_q <= 1'b1;
    else if (step)    pend_q <= 1'b0;
  end

  assign count_o = count_q;

  // R2: count holds without an enabled advance
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(count_q));
  // R2 / R9: increment wraps modulo 2^W
  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !pend_q && !clr) |=> count_q == W'($past(count_q) + 1'b1));
  // R3: pending load replaces the increment
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (step && pend_q && !clr) |=> count_q == $past(load_val_i));
  // R3: pending survives disabled edges
  p_pend_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !step && !clr) |=> pend_q);
endmodule

// File: rtl/sac_irq_ctrl.sv
module sac_irq_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] match_i,
  input  logic         clear_req_i,
  input  logic         mask_i,
  output logic         raw_o,
  output logic         irq_o
);
  logic hit;
  logic sticky_q;

  assign hit = (count_i == match_i);

  always_ff @(posedge clk) begin
    if (rst || clr)       sticky_q <= 1'b0;
    else if (hit)         sticky_q <= 1'b1;
    else if (clear_req_i) sticky_q <= 1'b0;
  end

  assign raw_o = sticky_q | hit;
  assign irq_o = raw_o & mask_i;

  // R4: equality latches into the sticky state
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr) |=> sticky_q);
  // R5: clear away from a match drops the state
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clear_req_i && !hit && !clr) |=> !sticky_q);
  // R7: interrupt only with raw status
  p_irq_raw_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> raw_o);
endmodule

// File: rtl/sac_reg_bank.sv
module sac_reg_bank
  import sec_alarm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      count_i,
  input  logic              raw_i,
  output logic [W-1:0]      rdata_o,
  output logic              en_o,
  output logic              mask_o,
  output logic [W-1:0]      match_o,
  output logic [W-1:0]      load_o,
  output logic              load_wr_o,
  output logic              clear_req_o,
  output logic              sw_clr_o
);
  logic [W-1:0] load_q;
  logic [W-1:0] match_q;
  logic         en_q;
  logic         mask_q;

  assign sw_clr_o    = wr_i && (addr_i == A_SWRST) && wdata_i[0];
  assign clear_req_o = wr_i && (addr_i == A_CLEAR) && wdata_i[0];
  assign load_wr_o   = wr_i && (addr_i == A_LOAD);

  always_ff @(posedge clk) begin
    if (rst || sw_clr_o) begin
      load_q  <= '0;
      match_q <= '0;
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        A_LOAD:  load_q  <= wdata_i;
        A_MATCH: match_q <= wdata_i;
        A_CTRL:  en_q    <= wdata_i[0];
        A_MASK:  mask_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_COUNT: rdata_o = count_i;
      A_LOAD:  rdata_o = load_q;
      A_MATCH: rdata_o = match_q;
      A_CTRL:  rdata_o[0] = en_q;
      A_MASK:  rdata_o[0] = mask_q;
      A_RAW:   rdata_o[0] = raw_i;
      default: rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign match_o = match_q;
  assign load_o  = load_q;

  // R8: software reset clears control state
  p_swrst_r8: assert property (@(posedge clk) disable iff (rst)
    sw_clr_o |=> (!en_q && !mask_q && match_q == '0 && load_q == '0));
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter
  import sec_alarm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             adv;
  logic             en;
  logic             mask;
  logic [CNT_W-1:0] match_val;
  logic [CNT_W-1:0] load_val;
  logic             load_wr;
  logic             clear_req;
  logic             sw_clr;
  logic [CNT_W-1:0] count;
  logic             raw;

  sac_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clr(sw_clr), .tick_i(tick_1hz), .adv_o(adv)
  );

  sac_reg_bank #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .count_i(count), .raw_i(raw),
    .rdata_o(bus_rdata), .en_o(en), .mask_o(mask), .match_o(match_val),
    .load_o(load_val), .load_wr_o(load_wr), .clear_req_o(clear_req),
    .sw_clr_o(sw_clr)
  );

  sac_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .clr(sw_clr), .adv_i(adv), .en_i(en),
    .load_wr_i(load_wr), .load_val_i(load_val), .count_o(count)
  );

  sac_irq_ctrl #(.W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .clr(sw_clr), .count_i(count),
    .match_i(match_val), .clear_req_i(clear_req), .mask_i(mask),
    .raw_o(raw), .irq_o(irq)
  );

  // R1: count register ignores bus writes
  p_count_ro_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_COUNT && !adv) |=> $stable(count));
endmodule

// File: tb/sec_alarm_counter_test.sv
module sec_alarm_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_alarm_counter uut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tick_1hz = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_check("R10 count", 3'd0, 32'd0);
    rd_check("R10 load", 3'd1, 32'd0);
    rd_check("R10 match", 3'd2, 32'd0);
    rd_check("R10 ctrl", 3'd3, 32'd0);
    rd_check("R10 mask", 3'd4, 32'd0);
    rd_check("R10 raw", 3'd5, 32'd1);
    check("R10 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_clear();
    wr(3'd6, 32'd1);
    rd_check("R6 clear at match", 3'd5, 32'd1);
    wr(3'd2, 32'd100);
    rd_check("R4 sticky after move", 3'd5, 32'd1);
    wr(3'd6, 32'd1);
    rd_check("R5 clear", 3'd5, 32'd0);
  endtask

  task automatic t_disabled();
    tick();
    rd_check("R2 disabled hold", 3'd0, 32'd0);
    wr(3'd0, 32'h1234);
    rd_check("R1 count write ignored", 3'd0, 32'd0);
  endtask

  task automatic t_load();
    wr(3'd1, 32'd50);
    rd_check("R3 no immediate load", 3'd0, 32'd0);
    tick();
    rd_check("R3 pending while disabled", 3'd0, 32'd0);
    wr(3'd3, 32'd1);
    tick();
    rd_check("R3 load at edge", 3'd0, 32'd50);
    tick();
    rd_check("R2 increment", 3'd0, 32'd51);
  endtask

  task automatic t_match();
    wr(3'd2, 32'd53);
    tick();
    rd_check("R2 count 52", 3'd0, 32'd52);
    rd_check("R4 no early raw", 3'd5, 32'd0);
    @(negedge clk);
    tick_1hz = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_check("R4 raw before count", 3'd5, 32'd0);
    @(posedge clk);
    @(negedge clk);
    rd_check("R4 count 53", 3'd0, 32'd53);
    rd_check("R4 raw same cycle", 3'd5, 32'd1);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    tick_1hz = 1'b0;
    repeat (4) @(posedge clk);
    wr(3'd4, 32'd1);
    #1 check("R7 unmasked irq", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'd1);
    rd_check("R6 clear while equal", 3'd5, 32'd1);
    tick();
    rd_check("R4 held after move", 3'd5, 32'd1);
    wr(3'd6, 32'd1);
    rd_check("R5 cleared", 3'd5, 32'd0);
    check("R7 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_wrap();
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'd0);
    tick();
    rd_check("R9 at max", 3'd0, 32'hFFFF_FFFF);
    rd_check("R9 no raw at max", 3'd5, 32'd0);
    tick();
    rd_check("R9 wrapped", 3'd0, 32'd0);
    rd_check("R9 raw at zero", 3'd5, 32'd1);
  endtask

  task automatic t_swrst();
    wr(3'd2, 32'd7);
    tick();
    wr(3'd7, 32'd1);
    rd_check("R8 count", 3'd0, 32'd0);
    rd_check("R8 match", 3'd2, 32'd0);
    rd_check("R8 ctrl", 3'd3, 32'd0);
    rd_check("R8 mask", 3'd4, 32'd0);
    rd_check("R8 load", 3'd1, 32'd0);
    check("R8 irq", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clear();
    t_disabled();
    t_load();
    t_match();
    t_wrap();
    t_swrst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule